// File: doc/BRIEF.md
# LIN Identifier Filter Bank

This block sits beside a LIN frame engine. When a protected identifier byte arrives, it checks the 6-bit identifier field against a bank of programmable filters. Each filter holds an identifier, a direction, a data length code, a checksum type and an enable. Neighbouring filters can also be joined into a pair that works in mask mode. One clock later the block reports whether an enabled filter matched and which filter it was. The filter number lets software index a buffer table directly. The block also supplies the winning filter's direction, length and checksum type, so the frame engine does not need software to program them for each frame.

The identifier arrives as a plain strobe plus a byte, and there is no back-pressure: the block takes a new identifier on any cycle and never stalls. The results are control outputs. They are held until the next strobe. Filter configuration comes in as static vectors from the register wrapper, which is outside this block.

Top module: `lin_id_filter_bank`

## Requirements
- R1: While reset is asserted, and until the first identifier strobe after it, every result output is 0.
- R2: Only bits [5:0] of the identifier byte are compared. The two parity bits [7:6] have no effect on the result.
- R3: A filter whose enable bit is 0 never produces a match.
- R4: When several filters match, the lowest-numbered one wins. `hit_idx_o` carries its number (0 to 7).
- R5: When pair bit p of `cfg_mask_pair` is 1, filter 2p holds the identifier and the identifier field of filter 2p+1 holds a mask. Mask bit 1 means "must be equal" and bit 0 means "don't care". A match reports index 2p and uses the settings of filter 2p.
- R6: While a pair is in mask mode, the odd filter of that pair never matches on its own.
- R7: On a match, the outputs carry the winning filter's settings. `hit_dir_o` uses 0 for receive and 1 for transmit. `hit_len_o` holds the byte count minus 1 (0 means 1 byte, 7 means 8 bytes). `hit_cks_o` is the filter's checksum-type bit.
- R8: `rx_hit_o` is 1 only when a filter matched and that filter's direction is receive (0).
- R9: The results change only on the clock edge that samples `id_valid_i` = 1. They hold their values while no strobe arrives, even if the identifier or configuration inputs change.
- R10: An identifier that matches no enabled filter gives `hit_o` = 0 and all other result outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Identifier strobe, one cycle |
| id_i | input | 8 | Protected identifier byte |
| cfg_id_i | input | 48 | Per-filter 6-bit identifier (or mask), filter i at [6i+5:6i] |
| cfg_dir_i | input | 8 | Per-filter direction, 0 = receive |
| cfg_len_i | input | 24 | Per-filter length code, filter i at [3i+2:3i] |
| cfg_cks_i | input | 8 | Per-filter checksum type |
| cfg_en_i | input | 8 | Per-filter enable |
| cfg_mask_pair_i | input | 4 | Per-pair mask mode |
| hit_o | output | 1 | A filter matched |
| hit_idx_o | output | 3 | Number of the winning filter |
| hit_dir_o | output | 1 | Winning direction |
| hit_len_o | output | 3 | Winning length code |
| hit_cks_o | output | 1 | Winning checksum type |
| rx_hit_o | output | 1 | Match on a receive filter |

## Verification
The bench feeds a fixed bank with several kinds of identifier. Some hit exact filters directly, and some hit them with the parity bits set, which separates a 6-bit comparison from an 8-bit one. Some land on overlapping filters, which shows whether priority goes to the lowest number. Others fall inside and outside a masked range, and one equals the stored mask value, which shows whether the odd filter of a pair is wrongly treated as an identifier. Further tests change the enables and the pair mode between strobes, and change inputs without a strobe. These separate enable handling, exact and mask behaviour, and output holding.

// File: rtl/lin_filt_pkg.sv
package lin_filt_pkg;
  localparam int PID_W = 8;
  localparam int ID_W  = 6;
  localparam int LEN_W = 3;

  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    dir_e             dir;
    logic [LEN_W-1:0] len;
    logic             cks;
  } filt_attr_t;
endpackage

// File: rtl/lin_filt_pair_cmp.sv
module lin_filt_pair_cmp
  import lin_filt_pkg::*;
(
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] even_id_i,
  input  logic [ID_W-1:0] odd_id_i,
  input  logic            even_en_i,
  input  logic            odd_en_i,
  input  logic            mask_mode_i,
  output logic            even_hit_o,
  output logic            odd_hit_o
);
  logic [ID_W-1:0] even_diff;
  logic [ID_W-1:0] odd_diff;

  assign even_diff = id_i ^ even_id_i;
  assign odd_diff  = id_i ^ odd_id_i;

  always_comb begin
    if (mask_mode_i) begin
      // odd filter's id field is the compare mask; it never hits by itself
      even_hit_o = even_en_i && ((even_diff & odd_id_i) == '0);
      odd_hit_o  = 1'b0;
    end else begin
      even_hit_o = even_en_i && (even_diff == '0);
      odd_hit_o  = odd_en_i  && (odd_diff  == '0);
    end
  end
endmodule

// File: rtl/lin_filt_prio.sv
module lin_filt_prio #(
  parameter int NUM   = 8,
  parameter int IDX_W = $clog2(NUM)
) (
  input  logic [NUM-1:0]   req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/lin_id_filter_bank.sv
module lin_id_filter_bank
  import lin_filt_pkg::*;
#(
  parameter int NUM_FILT = 8,
  localparam int NUM_PAIR = NUM_FILT / 2,
  localparam int IDX_W    = $clog2(NUM_FILT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      id_valid_i,
  input  logic [PID_W-1:0]          id_i,
  input  logic [NUM_FILT*ID_W-1:0]  cfg_id_i,
  input  logic [NUM_FILT-1:0]       cfg_dir_i,
  input  logic [NUM_FILT*LEN_W-1:0] cfg_len_i,
  input  logic [NUM_FILT-1:0]       cfg_cks_i,
  input  logic [NUM_FILT-1:0]       cfg_en_i,
  input  logic [NUM_PAIR-1:0]       cfg_mask_pair_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          hit_idx_o,
  output logic                      hit_dir_o,
  output logic [LEN_W-1:0]          hit_len_o,
  output logic                      hit_cks_o,
  output logic                      rx_hit_o
);
  filt_attr_t        attr [NUM_FILT];
  logic [NUM_FILT-1:0] hit_vec;
  logic [ID_W-1:0]   id_field;
  logic              found;
  logic [IDX_W-1:0]  win_idx;
  filt_attr_t        win_attr;

  assign id_field = id_i[ID_W-1:0];

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_attr
    assign attr[f].id  = cfg_id_i[f*ID_W +: ID_W];
    assign attr[f].dir = dir_e'(cfg_dir_i[f]);
    assign attr[f].len = cfg_len_i[f*LEN_W +: LEN_W];
    assign attr[f].cks = cfg_cks_i[f];
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    lin_filt_pair_cmp u_cmp (
      .id_i        (id_field),
      .even_id_i   (attr[2*p].id),
      .odd_id_i    (attr[2*p+1].id),
      .even_en_i   (cfg_en_i[2*p]),
      .odd_en_i    (cfg_en_i[2*p+1]),
      .mask_mode_i (cfg_mask_pair_i[p]),
      .even_hit_o  (hit_vec[2*p]),
      .odd_hit_o   (hit_vec[2*p+1])
    );
  end

  lin_filt_prio #(.NUM(NUM_FILT), .IDX_W(IDX_W)) u_prio (
    .req_i   (hit_vec),
    .found_o (found),
    .idx_o   (win_idx)
  );

  assign win_attr = attr[win_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
      hit_dir_o <= 1'b0;
      hit_len_o <= '0;
      hit_cks_o <= 1'b0;
      rx_hit_o  <= 1'b0;
    end else if (id_valid_i) begin
      hit_o     <= found;
      hit_idx_o <= found ? win_idx : '0;
      hit_dir_o <= found && (win_attr.dir == DIR_TX);
      hit_len_o <= found ? win_attr.len : '0;
      hit_cks_o <= found && win_attr.cks;
      rx_hit_o  <= found && (win_attr.dir == DIR_RX);
    end
  end
endmodule

// File: rtl/lin_id_filter_bank_chk.sv
module lin_id_filter_bank_chk #(
  parameter int NUM_FILT = 8,
  localparam int IDX_W = $clog2(NUM_FILT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                id_valid_i,
  input logic [NUM_FILT-1:0] cfg_en_i,
  input logic                hit_o,
  input logic [IDX_W-1:0]    hit_idx_o,
  input logic                hit_dir_o,
  input logic [2:0]          hit_len_o,
  input logic                hit_cks_o,
  input logic                rx_hit_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> !hit_o && !rx_hit_o && hit_idx_o == '0);

  assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid_i && cfg_en_i == '0 |=> !hit_o);

  assert_rx_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit_o |-> hit_o && !hit_dir_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid_i |=> $stable(hit_o) && $stable(hit_idx_o) && $stable(hit_len_o)
                    && $stable(hit_dir_o) && $stable(hit_cks_o) && $stable(rx_hit_o));

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> hit_idx_o == '0 && hit_len_o == '0 && !hit_dir_o && !hit_cks_o && !rx_hit_o);
endmodule

bind lin_id_filter_bank lin_id_filter_bank_chk #(.NUM_FILT(NUM_FILT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .id_valid_i (id_valid_i),
  .cfg_en_i   (cfg_en_i),
  .hit_o      (hit_o),
  .hit_idx_o  (hit_idx_o),
  .hit_dir_o  (hit_dir_o),
  .hit_len_o  (hit_len_o),
  .hit_cks_o  (hit_cks_o),
  .rx_hit_o   (rx_hit_o)
);

// File: tb/lin_id_filter_bank_test.sv
module lin_id_filter_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_valid_i = 1'b0;
  logic [7:0]  id_i = '0;
  logic [47:0] cfg_id_i = '0;
  logic [7:0]  cfg_dir_i = '0;
  logic [23:0] cfg_len_i = '0;
  logic [7:0]  cfg_cks_i = '0;
  logic [7:0]  cfg_en_i = '0;
  logic [3:0]  cfg_mask_pair_i = '0;
  logic        hit_o, hit_dir_o, hit_cks_o, rx_hit_o;
  logic [2:0]  hit_idx_o, hit_len_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lin_id_filter_bank uut (.*);

  // entry: {id[8], hit, idx[3], dir, len[3], cks, rx}
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {8'h10, 1'b1, 3'd0, 1'b0, 3'd7, 1'b1, 1'b1},  // R4 R7 R8: f0 beats f1
    {8'hD0, 1'b1, 3'd0, 1'b0, 3'd7, 1'b1, 1'b1},  // R2 parity ignored
    {8'h20, 1'b1, 3'd2, 1'b1, 3'd3, 1'b1, 1'b0},  // R7 R8 transmit filter
    {8'h05, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0},  // R3 disabled f3
    {8'h32, 1'b1, 3'd4, 1'b0, 3'd4, 1'b0, 1'b1},  // R5 mask range
    {8'h31, 1'b1, 3'd4, 1'b0, 3'd4, 1'b0, 1'b1},  // R4 R5 pair beats f6
    {8'h3C, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0},  // R6 mask value not an id
    {8'h7F, 1'b1, 3'd7, 1'b1, 3'd0, 1'b0, 1'b0},  // R2 R7 length code 0
    {8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0}   // R10 miss
  };

  task automatic set_filt(input int f, input logic [5:0] id, input logic dir,
                          input logic [2:0] len, input logic cks, input logic en);
    cfg_id_i[f*6 +: 6] = id;
    cfg_dir_i[f]       = dir;
    cfg_len_i[f*3 +: 3] = len;
    cfg_cks_i[f]       = cks;
    cfg_en_i[f]        = en;
  endtask

  task automatic strobe(input logic [7:0] id);
    @(negedge clk);
    id_i = id;
    id_valid_i = 1'b1;
    @(negedge clk);
    id_valid_i = 1'b0;
  endtask

  task automatic check(input string req, input logic [9:0] exp);
    logic [9:0] act;
    act = {hit_o, hit_idx_o, hit_dir_o, hit_len_o, hit_cks_o, rx_hit_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_filt(0, 6'h10, 1'b0, 3'd7, 1'b1, 1'b1);
    set_filt(1, 6'h10, 1'b1, 3'd2, 1'b0, 1'b1);
    set_filt(2, 6'h20, 1'b1, 3'd3, 1'b1, 1'b1);
    set_filt(3, 6'h05, 1'b0, 3'd1, 1'b1, 1'b0);
    set_filt(4, 6'h30, 1'b0, 3'd4, 1'b0, 1'b1);
    set_filt(5, 6'h3C, 1'b1, 3'd6, 1'b1, 1'b1);
    set_filt(6, 6'h31, 1'b0, 3'd5, 1'b1, 1'b1);
    set_filt(7, 6'h3F, 1'b1, 3'd0, 1'b0, 1'b1);
    cfg_mask_pair_i = 4'b0100;

    repeat (3) @(negedge clk);
    check("R1 in reset", 10'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 10'b0);

    for (int v = 0; v < NV; v++) begin
      strobe(VEC[v][17:10]);
      check($sformatf("R4/R5/R7 vector %0d", v), VEC[v][9:0]);
    end

    // R9: inputs change without a strobe, outputs hold f7 result
    strobe(8'h3F);
    @(negedge clk);
    id_i = 8'h10;
    cfg_en_i = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 hold", {1'b1, 3'd7, 1'b1, 3'd0, 1'b0, 1'b0});
    cfg_en_i = 8'b1111_0111;

    // R3 R4: disable f0, f1 now wins
    cfg_en_i[0] = 1'b0;
    strobe(8'h10);
    check("R3 R4 f1 after f0 off", {1'b1, 3'd1, 1'b1, 3'd2, 1'b0, 1'b0});
    cfg_en_i[0] = 1'b1;

    // R6: odd filter in exact mode does match its own id
    cfg_mask_pair_i = 4'b0000;
    strobe(8'h3C);
    check("R6 odd exact", {1'b1, 3'd5, 1'b1, 3'd6, 1'b1, 1'b0});
    strobe(8'h32);
    check("R5 exact off range", 10'b0);
    strobe(8'h31);
    check("R4 R5 f6 exact", {1'b1, 3'd6, 1'b0, 3'd5, 1'b1, 1'b1});

    // R5: mask of all ones behaves as exact compare
    cfg_mask_pair_i = 4'b0100;
    cfg_id_i[5*6 +: 6] = 6'h3F;
    strobe(8'h30);
    check("R5 full mask", {1'b1, 3'd4, 1'b0, 3'd4, 1'b0, 1'b1});
    strobe(8'h33);
    check("R5 full mask miss, f6 out", 10'b0);
    // R5: empty mask accepts everything -> pair 2 wins over f6/f7, lower f0..f2 still first
    cfg_id_i[5*6 +: 6] = 6'h00;
    strobe(8'h3F);
    check("R5 empty mask", {1'b1, 3'd4, 1'b0, 3'd4, 1'b0, 1'b1});
    strobe(8'h20);
    check("R4 f2 over mask", {1'b1, 3'd2, 1'b1, 3'd3, 1'b1, 1'b0});

    // R1: reset clears a held match
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset", 10'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after second reset", 10'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule